// File: doc/BRIEF.md
# EPP Host Cycle Engine

This block turns host register accesses into Enhanced Parallel Port (EPP) cycles on the peripheral pins. The host sees eight byte-wide offsets. Offsets 0 to 2 are plain parallel port registers: a data latch, a status byte and a control byte. Offset 3 runs an address cycle. Offsets 4 to 7 run data cycles. While a cycle runs, the hardware takes over the write line, the address strobe and the data strobe. It paces them on the peripheral's WAIT# line, which passes through a synchroniser first.

The host interface is a valid/ready channel. A request is accepted on the edge where `host_valid` and `host_ready` are both high. Once the host has raised `host_valid`, it must hold the address, the write flag and the write data steady until that edge. `host_rdata` is valid during that same cycle.

Register accesses, and any access while EPP is disabled, complete in the cycle they are presented. An EPP access holds `host_ready` low until the peripheral responds or a watchdog of `TIMEOUT_CYC` cycles runs out. When the watchdog runs out, the cycle is aborted and a sticky timeout flag is set.

Top module: `epp_cycle_ctrl`

## Requirements
- R1: After reset, stb_n, afd_n and slin_n are high, init_n is low, pd_oe is high, host_ready is high while host_valid is low, and the status byte reads 0.
- R2: Outside an EPP cycle, the pins follow the control byte: stb_n = not bit 0, afd_n = not bit 1, init_n = bit 2, slin_n = not bit 3, and pd_oe = not bit 5. Reading offset 2 returns the control byte with bits 7:6 at zero.
- R3: Writing offset 0 sets the byte on pd_out outside EPP cycles. Reading offset 0 returns pd_in. Accesses to offsets 0 to 2 complete in the cycle they are presented (host_ready high while idle).
- R4: With epp_en high, offset 3 starts an address cycle and offsets 4 to 7 start data cycles. In the strobe phase, an address cycle drives slin_n low with afd_n high, and a data cycle drives afd_n low with slin_n high. stb_n is low exactly for writes, pd_oe equals the write flag, and init_n keeps control bit 2.
- R5: In a write cycle, pd_out carries the host byte from the start of the cycle. Once WAIT# is seen high, the strobe rises and host_ready is high for one cycle. stb_n then stays low until WAIT# is seen low again.
- R6: A read cycle releases PD (pd_oe low), captures pd_in when WAIT# is seen high, and returns that byte on host_rdata with host_ready.
- R7: If wait_n rises D cycles after the cycle starts, host_ready rises D + SYNC_STAGES + 1 cycles after the request was presented.
- R8: If the synchronised WAIT# is still low after TIMEOUT_CYC strobe cycles, the cycle is aborted. host_ready rises exactly TIMEOUT_CYC cycles after the request, a read returns 8'hFF, the pins return to the control byte values, and status bit 0 becomes 1.
- R9: Status bit 0 stays set until the host writes offset 1 with bit 0 = 1. Status bits 7:1 read 0.
- R10: With epp_en low, accesses to offsets 3 to 7 complete at once, read 0, and leave the pins unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| epp_en | input | 1 | Enables EPP decoding of offsets 3 to 7 |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Request accepted / cycle complete |
| host_addr | input | 3 | Register offset |
| host_we | input | 1 | 1 = write, 0 = read |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, valid with host_ready |
| pd_out | output | 8 | Parallel data driven to the pins |
| pd_in | input | 8 | Parallel data sampled from the pins |
| pd_oe | output | 1 | Parallel data output enable |
| stb_n | output | 1 | Strobe / EPP write line, active low |
| afd_n | output | 1 | Autofeed / EPP data strobe, active low |
| init_n | output | 1 | Initialise line |
| slin_n | output | 1 | Select-in / EPP address strobe, active low |
| wait_n | input | 1 | Peripheral WAIT#, asynchronous |

## Verification
Register accesses take effect on the accepting edge. The bench therefore drives them just after a falling edge and samples ready and read data 1 ns later. It checks the pins at the next falling edge.

For EPP cycles, the bench's peripheral raises wait_n after a swept delay D, counted in falling edges from the first one that shows the strobe low. The bench counts falling edges until host_ready is seen. It expects D + 3 with the two-stage synchroniser, or exactly TIMEOUT_CYC when D + 3 exceeds it. All outputs are sampled on falling edges, so every register stage between an edge and its result is counted whole.

The bench sweeps every offset from 3 to 7, both directions and every D from 0 to TIMEOUT_CYC. After each trial it checks the idle pins and the sticky status bit.

// File: rtl/epp_cycle_pkg.sv
package epp_cycle_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STROBE = 2'd1,
    ST_DONE   = 2'd2,
    ST_TAIL   = 2'd3
  } epp_state_e;

  localparam logic [2:0] OFS_DATA  = 3'd0;
  localparam logic [2:0] OFS_STAT  = 3'd1;
  localparam logic [2:0] OFS_CTRL  = 3'd2;
  localparam logic [2:0] OFS_EADDR = 3'd3;

  localparam int CB_STB  = 0;
  localparam int CB_AFD  = 1;
  localparam int CB_INIT = 2;
  localparam int CB_SLIN = 3;
  localparam int CB_DIR  = 5;
  localparam int CTRL_W  = 6;
endpackage

// File: rtl/epp_cycle_sync.sv
module epp_cycle_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= RESET_VAL;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/epp_cycle_watchdog.sv
module epp_cycle_watchdog #(
  parameter int LIMIT = 330000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (!run)        cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == LAST);

  // R8: the count never passes the limit and restarts outside the strobe phase
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n) cnt <= LAST);
  p_cnt_idle_r8:  assert property (@(posedge clk) disable iff (!rst_n) !run |=> cnt == '0);
endmodule

// File: rtl/epp_cycle_regs.sv
module epp_cycle_regs
  import epp_cycle_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] pd_in,
  input  logic              set_timeout,
  output logic [CTRL_W-1:0] ctrl,
  output logic [DATA_W-1:0] spp_data,
  output logic              timeout_flag,
  output logic [DATA_W-1:0] rd_val
);
  logic clr_req;

  assign clr_req = wr_en && (addr == OFS_STAT) && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl         <= '0;
      spp_data     <= '0;
      timeout_flag <= 1'b0;
    end else begin
      if (wr_en && addr == OFS_CTRL) ctrl     <= wdata[CTRL_W-1:0];
      if (wr_en && addr == OFS_DATA) spp_data <= wdata;
      if (set_timeout)               timeout_flag <= 1'b1;
      else if (clr_req)              timeout_flag <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr)
      OFS_DATA: rd_val = pd_in;
      OFS_STAT: rd_val = {{(DATA_W-1){1'b0}}, timeout_flag};
      OFS_CTRL: rd_val = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
      default:  rd_val = '0;
    endcase
  end

  // R8: an abort always leaves the flag set
  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_timeout |=> timeout_flag);
  // R9: only a clearing write takes the flag down
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_flag && !clr_req) |=> timeout_flag);
endmodule

// File: rtl/epp_cycle_hs.sv
module epp_cycle_hs
  import epp_cycle_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_addr,
  input  logic              start_we,
  input  logic [DATA_W-1:0] start_byte,
  input  logic              wait_hi,
  input  logic              expire,
  input  logic [DATA_W-1:0] pd_in,
  output epp_state_e        state,
  output logic              cyc_addr,
  output logic              cyc_we,
  output logic [DATA_W-1:0] cyc_byte,
  output logic [DATA_W-1:0] rd_byte,
  output logic              aborted,
  output logic              set_timeout,
  output logic              run
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cyc_addr <= 1'b0;
      cyc_we   <= 1'b0;
      cyc_byte <= '0;
      rd_byte  <= '0;
      aborted  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state    <= ST_STROBE;
          cyc_addr <= start_addr;
          cyc_we   <= start_we;
          cyc_byte <= start_byte;
          aborted  <= 1'b0;
        end
        ST_STROBE: if (wait_hi) begin
          state <= ST_DONE;
          if (!cyc_we) rd_byte <= pd_in;
        end else if (expire) begin
          state   <= ST_DONE;
          aborted <= 1'b1;
          rd_byte <= '1;
        end
        ST_DONE: state <= aborted ? ST_IDLE : ST_TAIL;
        ST_TAIL: if (!wait_hi) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign run         = (state == ST_STROBE);
  assign set_timeout = run && !wait_hi && expire;

  // R5: completion is a single-cycle phase
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_DONE |=> state != ST_DONE);
  // R5: the write line is released once WAIT# is seen low again
  p_tail_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TAIL && !wait_hi) |=> state == ST_IDLE);
  // R8: an abort happens only when the watchdog runs out
  p_abort_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aborted) |-> $past(expire));
endmodule

// File: rtl/epp_cycle_ctrl.sv
module epp_cycle_ctrl
  import epp_cycle_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int TIMEOUT_CYC = 330000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              epp_en,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic [2:0]        host_addr,
  input  logic              host_we,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic [DATA_W-1:0] pd_out,
  input  logic [DATA_W-1:0] pd_in,
  output logic              pd_oe,
  output logic              stb_n,
  output logic              afd_n,
  output logic              init_n,
  output logic              slin_n,
  input  logic              wait_n
);
  epp_state_e        state;
  logic              cyc_addr, cyc_we, aborted, set_timeout, run, expire, wait_hi;
  logic [DATA_W-1:0] cyc_byte, rd_byte, spp_data, reg_rd;
  logic [CTRL_W-1:0] ctrl;
  logic              timeout_flag;
  logic              idle, epp_hit, start, reg_wr, hw_own;

  assign idle    = (state == ST_IDLE);
  assign epp_hit = epp_en && (host_addr >= OFS_EADDR);
  assign start   = idle && host_valid && epp_hit;
  assign reg_wr  = idle && host_valid && host_we && (host_addr < OFS_EADDR);

  epp_cycle_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(wait_n), .q(wait_hi)
  );

  epp_cycle_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
    .clk(clk), .rst_n(rst_n), .run(run), .expire(expire)
  );

  epp_cycle_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(host_addr),
    .wdata(host_wdata), .pd_in(pd_in), .set_timeout(set_timeout),
    .ctrl(ctrl), .spp_data(spp_data), .timeout_flag(timeout_flag), .rd_val(reg_rd)
  );

  epp_cycle_hs #(.DATA_W(DATA_W)) u_hs (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(host_addr == OFS_EADDR),
    .start_we(host_we), .start_byte(host_wdata), .wait_hi(wait_hi),
    .expire(expire), .pd_in(pd_in), .state(state), .cyc_addr(cyc_addr),
    .cyc_we(cyc_we), .cyc_byte(cyc_byte), .rd_byte(rd_byte), .aborted(aborted),
    .set_timeout(set_timeout), .run(run)
  );

  // Host channel: registers answer at once, EPP cycles answer in the done phase
  assign host_ready = (state == ST_DONE) || (idle && !epp_hit);
  assign host_rdata = (state == ST_DONE) ? rd_byte : (epp_hit ? '0 : reg_rd);

  // Pins are owned by the handshake except after an abort
  assign hw_own = (state == ST_STROBE) ||
                  ((state == ST_DONE || state == ST_TAIL) && !aborted);

  assign stb_n  = hw_own ? !cyc_we : !ctrl[CB_STB];
  assign afd_n  = hw_own ? !(run && !cyc_addr) : !ctrl[CB_AFD];
  assign slin_n = hw_own ? !(run && cyc_addr) : !ctrl[CB_SLIN];
  assign init_n = ctrl[CB_INIT];
  assign pd_oe  = hw_own ? cyc_we : !ctrl[CB_DIR];
  assign pd_out = hw_own ? cyc_byte : spp_data;

  // R4: only one of the two strobes is active in the strobe phase
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (afd_n != slin_n));
  // R3: a request waiting for ready is held steady by the host
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !host_ready) |=> (host_valid && $stable(host_addr) &&
                                     $stable(host_we) && $stable(host_wdata)));
  // R5: ready is never given while a strobe is still low
  p_ready_after_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |-> (afd_n || !ctrl[CB_AFD] && aborted) && (slin_n || !ctrl[CB_SLIN] && aborted));
endmodule

// File: tb/epp_cycle_ctrl_bench.sv
`timescale 1ns/1ps
module epp_cycle_ctrl_bench;
  localparam int T = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       epp_en = 1'b0;
  logic       host_valid = 1'b0;
  logic       host_ready;
  logic [2:0] host_addr = 3'd0;
  logic       host_we = 1'b0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic [7:0] pd_out;
  logic [7:0] pd_in = 8'd0;
  logic       pd_oe, stb_n, afd_n, init_n, slin_n;
  logic       wait_n = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  epp_cycle_ctrl #(.DATA_W(8), .TIMEOUT_CYC(T), .SYNC_STAGES(2)) u_epp_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .epp_en(epp_en), .host_valid(host_valid),
    .host_ready(host_ready), .host_addr(host_addr), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .pd_out(pd_out),
    .pd_in(pd_in), .pd_oe(pd_oe), .stb_n(stb_n), .afd_n(afd_n),
    .init_n(init_n), .slin_n(slin_n), .wait_n(wait_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_acc(input logic [2:0] a, input logic we, input logic [7:0] wd,
                         output logic [7:0] rd, output logic rdy);
    @(negedge clk);
    host_valid = 1'b1; host_addr = a; host_we = we; host_wdata = wd;
    #1;
    rdy = host_ready;
    rd  = host_rdata;
    @(posedge clk);
    #1;
    host_valid = 1'b0; host_we = 1'b0;
  endtask

  task automatic epp_trial(input logic [2:0] a, input logic we, input int d);
    logic [7:0] b;
    logic       exp_to;
    int         exp_lat;
    int         lat;
    logic [7:0] rd;
    logic       rdy;
    logic [7:0] st;
    b       = 8'(a * 37 + d * 11 + (we ? 5 : 0));
    exp_to  = (d + 3 > T);
    exp_lat = exp_to ? T : d + 3;
    pd_in   = ~b;
    @(negedge clk);
    host_valid = 1'b1; host_addr = a; host_we = we; host_wdata = b;
    lat = 0;
    fork
      begin
        @(negedge clk);
        while (!host_ready) begin
          lat++;
          @(negedge clk);
        end
        chk("R7/R8 ready latency", 32'(lat), 32'(exp_lat));
        if (!we) chk("R6/R8 read byte", {24'd0, host_rdata}, {24'd0, exp_to ? 8'hFF : ~b});
        @(posedge clk);
        #1;
        host_valid = 1'b0; host_we = 1'b0;
      end
      begin
        @(negedge clk);
        while ((a == 3'd3) ? slin_n : afd_n) @(negedge clk);
        chk("R4 stb_n in strobe", {31'd0, stb_n}, {31'd0, !we});
        chk("R4 other strobe high", {31'd0, (a == 3'd3) ? afd_n : slin_n}, 32'd1);
        chk("R4 pd_oe", {31'd0, pd_oe}, {31'd0, we});
        chk("R4 init_n", {31'd0, init_n}, 32'd1);
        if (we) chk("R5 pd_out byte", {24'd0, pd_out}, {24'd0, b});
        repeat (d) @(negedge clk);
        wait_n = 1'b1;
        while ((a == 3'd3) ? !slin_n : !afd_n) @(negedge clk);
        if (!exp_to && we) chk("R5 write held after strobe", {31'd0, stb_n}, 32'd0);
        wait_n = 1'b0;
      end
    join
    repeat (6) @(negedge clk);
    chk("R2 idle pins", {28'd0, stb_n, afd_n, slin_n, pd_oe}, 32'hF);
    chk("R2 pd_out back to latch", {24'd0, pd_out}, 32'h5A);
    reg_acc(3'd1, 1'b0, 8'd0, st, rdy);
    chk("R8 status after trial", {24'd0, st}, {31'd0, exp_to});
    if (exp_to) begin
      reg_acc(3'd1, 1'b0, 8'd0, st, rdy);
      chk("R9 flag sticky", {24'd0, st}, 32'd1);
      reg_acc(3'd1, 1'b1, 8'h01, rd, rdy);
      reg_acc(3'd1, 1'b0, 8'd0, st, rdy);
      chk("R9 flag cleared", {24'd0, st}, 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic       rdy;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 strobes", {29'd0, stb_n, afd_n, slin_n}, 32'h7);
    chk("R1 init_n", {31'd0, init_n}, 32'd0);
    chk("R1 pd_oe", {31'd0, pd_oe}, 32'd1);
    chk("R1 host_ready idle", {31'd0, host_ready}, 32'd1);
    reg_acc(3'd1, 1'b0, 8'd0, rd, rdy);
    chk("R1 status", {24'd0, rd}, 32'd0);

    // R2 control byte sweep
    for (int c = 0; c < 64; c++) begin
      reg_acc(3'd2, 1'b1, 8'(c), rd, rdy);
      chk("R3 ctrl write ready", {31'd0, rdy}, 32'd1);
      @(negedge clk);
      chk("R2 pins from ctrl", {27'd0, stb_n, afd_n, init_n, slin_n, pd_oe},
          {27'd0, !c[0], !c[1], c[2], !c[3], !c[5]});
      reg_acc(3'd2, 1'b0, 8'd0, rd, rdy);
      chk("R2 ctrl readback", {24'd0, rd}, 32'(c));
    end
    reg_acc(3'd2, 1'b1, 8'h04, rd, rdy);

    // R3 data latch and pin read
    reg_acc(3'd0, 1'b1, 8'h5A, rd, rdy);
    chk("R3 data write ready", {31'd0, rdy}, 32'd1);
    @(negedge clk);
    chk("R3 pd_out", {24'd0, pd_out}, 32'h5A);
    pd_in = 8'hC3;
    reg_acc(3'd0, 1'b0, 8'd0, rd, rdy);
    chk("R3 pd_in read", {24'd0, rd}, 32'hC3);

    // R10 EPP offsets while disabled
    for (int a = 3; a < 8; a++) begin
      reg_acc(3'(a), 1'b1, 8'hA5, rd, rdy);
      chk("R10 write ready", {31'd0, rdy}, 32'd1);
      reg_acc(3'(a), 1'b0, 8'd0, rd, rdy);
      chk("R10 read ready", {31'd0, rdy}, 32'd1);
      chk("R10 read zero", {24'd0, rd}, 32'd0);
      @(negedge clk);
      chk("R10 pins unchanged", {27'd0, stb_n, afd_n, slin_n, pd_oe, init_n}, 32'h1F);
      chk("R10 pd_out unchanged", {24'd0, pd_out}, 32'h5A);
    end

    // R4..R9 EPP sweep
    epp_en = 1'b1;
    for (int a = 3; a < 8; a++)
      for (int w = 0; w < 2; w++)
        for (int d = 0; d <= T; d++)
          epp_trial(3'(a), w[0], d);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule